// File: doc/BRIEF.md
# Keyed Segmented Flash Array Controller

This block models a small non-volatile information store: two segments of 128 bytes each, mapped at byte addresses 0x1000 to 0x10FF, behind a controller that guards every change to the array. A processor-style byte bus reads the array directly and without delay. Writes on the same bus change the array only when the controller has been armed. Before a write, software selects program or erase mode and clears the lock bit. Afterwards it returns to idle mode and sets the lock bit again.

Programming follows flash rules: it can only clear bits, so the stored byte becomes the old byte ANDed with the written byte. Erasing returns a whole segment to 0xFF. A dummy write of any value to any address inside that segment starts the erase. Three control registers hold the mode, the timing-clock setting and the lock. Each register write carries an 8-bit password in its upper byte, and a write with a wrong password is discarded. After every accepted program or erase, a busy interval is timed in divided-clock ticks. Array writes made during that interval are refused.

Top module: `kfc_top`

## Requirements
- R1: After reset the lock is set, both mode bits are clear, busy and both violation flags are low, the clock-range flag is low, and every array byte reads 0xFF.
- R2: An accepted program write to array byte A with data D leaves byte A equal to its previous value AND D, and no other byte changes.
- R3: An accepted erase write to any address inside a segment sets all bytes of that segment to 0xFF and leaves the other segment unchanged.
- R4: Only addresses 0x1000 to 0x10FF reach the array. A read outside that window returns 0x00. A write outside it changes nothing and sets the access-violation flag.
- R5: A register write whose bits [15:8] differ from 0xA5 changes no register and sets the key-violation flag. A write with the correct key to select value 3 changes nothing.
- R6: A bus write made while the lock is set, or while both mode bits are clear, leaves the array unchanged and sets the access-violation flag.
- R7: The clock register (select 1) holds a source bit in [7] and a divider in [5:0]. Source 0 runs at 8000 kHz and source 1 at 1000 kHz. With rate = source / (divider + 1) in whole kHz, the clock-range flag is high exactly when the rate is below 250 or above 470. The register resets to 0x82.
- R8: The mode register (select 0) holds a busy length field in [7:4]. After an accepted program or erase, busy stays high for (field + 1) × (divider + 1) clock cycles. A bus write while busy is refused, leaves the array unchanged and sets the access-violation flag.
- R9: The lock register (select 2) holds the lock in bit [0]. Writing it with the correct key and bit [7] set clears both violation flags.
- R10: Mode register bit [0] selects program and bit [1] selects erase. When both bits are set, erase takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 mode, 1 clock, 2 lock, 3 none |
| reg_wdata | input | 16 | Key in [15:8], register value in [7:0] |
| bus_we | input | 1 | Array bus write strobe |
| bus_addr | input | 16 | Array byte address |
| bus_wdata | input | 8 | Array write data |
| bus_rdata | output | 8 | Array read data (combinational) |
| mode_o | output | 2 | Current mode bits {erase, program} |
| locked_o | output | 1 | Lock bit |
| busy_o | output | 1 | Program/erase busy interval |
| clk_bad_o | output | 1 | Divided timing clock is outside 250 to 470 kHz |
| key_viol_o | output | 1 | Sticky wrong-key flag |
| acc_viol_o | output | 1 | Sticky refused-array-write flag |

## Verification
The assertions assume that software leaves the clock divider and the busy length unchanged while busy is high, and that register and bus writes are single-cycle strobes. The bench follows both assumptions. It changes the clock and mode registers only after it has waited for busy to fall. It drives every strobe for exactly one cycle, between falling edges. The stimulus covers every divider value for both sources, every address in the window, both segments, and several busy lengths.

// File: rtl/kfc_pkg.sv
package kfc_pkg;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_CLK  = 2'd1,
    SEL_LOCK = 2'd2,
    SEL_NONE = 2'd3
  } kfc_sel_e;

  // Divided timing-clock rate in whole kHz, flagged when outside [lo, hi].
  function automatic logic clk_out_of_range(input int unsigned src_khz,
                                            input int unsigned div_m1,
                                            input int unsigned lo_khz,
                                            input int unsigned hi_khz);
    int unsigned rate;
    rate = src_khz / (div_m1 + 1);
    return (rate < lo_khz) || (rate > hi_khz);
  endfunction

  // Flash programming can only pull bits low.
  function automatic logic [7:0] prog_merge(input logic [7:0] old_b,
                                            input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

endpackage

// File: rtl/kfc_regs.sv
module kfc_regs #(
  parameter logic [7:0]  KEY       = 8'hA5,
  parameter int unsigned SRC0_KHZ  = 8000,
  parameter int unsigned SRC1_KHZ  = 1000,
  parameter int unsigned FMIN_KHZ  = 250,
  parameter int unsigned FMAX_KHZ  = 470,
  parameter int          DIV_W     = 6,
  parameter int          LEN_W     = 4,
  parameter logic [7:0]  CLK_RESET = 8'h82
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [15:0]      reg_wdata,
  input  logic             acc_set,
  output logic             mode_prog,
  output logic             mode_erase,
  output logic             locked,
  output logic [LEN_W-1:0] len_m1,
  output logic [DIV_W-1:0] div_m1,
  output logic             clk_bad,
  output logic             key_viol,
  output logic             acc_viol
);
  import kfc_pkg::*;

  logic             key_ok;
  logic             key_fail_ev;
  logic             mode_wr_ev, clk_wr_ev, lock_wr_ev, clr_ev;
  logic [1:0]       mode_q;
  logic [LEN_W-1:0] len_q;
  logic             src_q;
  logic [DIV_W-1:0] div_q;
  logic             lock_q;

  assign key_ok      = (reg_wdata[15:8] == KEY);
  assign key_fail_ev = reg_we && !key_ok;
  assign mode_wr_ev  = reg_we && key_ok && (kfc_sel_e'(reg_sel) == SEL_MODE);
  assign clk_wr_ev   = reg_we && key_ok && (kfc_sel_e'(reg_sel) == SEL_CLK);
  assign lock_wr_ev  = reg_we && key_ok && (kfc_sel_e'(reg_sel) == SEL_LOCK);
  assign clr_ev      = lock_wr_ev && reg_wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 2'b00;
      len_q    <= '0;
      src_q    <= CLK_RESET[7];
      div_q    <= CLK_RESET[DIV_W-1:0];
      lock_q   <= 1'b1;
      key_viol <= 1'b0;
      acc_viol <= 1'b0;
    end else begin
      if (mode_wr_ev) begin
        mode_q <= reg_wdata[1:0];
        len_q  <= reg_wdata[4 +: LEN_W];
      end
      if (clk_wr_ev) begin
        src_q <= reg_wdata[7];
        div_q <= reg_wdata[DIV_W-1:0];
      end
      if (lock_wr_ev) lock_q <= reg_wdata[0];
      if (key_fail_ev)  key_viol <= 1'b1;
      else if (clr_ev)  key_viol <= 1'b0;
      if (acc_set)      acc_viol <= 1'b1;
      else if (clr_ev)  acc_viol <= 1'b0;
    end
  end

  assign mode_prog  = mode_q[0];
  assign mode_erase = mode_q[1];
  assign locked     = lock_q;
  assign len_m1     = len_q;
  assign div_m1     = div_q;
  assign clk_bad    = clk_out_of_range(src_q ? SRC1_KHZ : SRC0_KHZ, 32'(div_q),
                                       FMIN_KHZ, FMAX_KHZ);

  assert_bad_key_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_fail_ev |=> ($stable(mode_q) && $stable(lock_q) && $stable(div_q) && key_viol));

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !acc_set) |=> (!key_viol && !acc_viol));

endmodule

// File: rtl/kfc_timer.sv
module kfc_timer #(
  parameter int DIV_W = 6,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] div_m1,
  input  logic [LEN_W-1:0] len_m1,
  output logic             busy
);
  localparam int CW = LEN_W + 1;

  logic [DIV_W-1:0] div_cnt;
  logic [CW-1:0]    busy_cnt;
  logic             tick_ev;

  assign busy    = (busy_cnt != '0);
  assign tick_ev = busy && (div_cnt >= div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      busy_cnt <= '0;
    end else if (start) begin
      div_cnt  <= '0;
      busy_cnt <= CW'(len_m1) + CW'(1);
    end else if (tick_ev) begin
      div_cnt  <= '0;
      busy_cnt <= busy_cnt - CW'(1);
    end else if (busy) begin
      div_cnt  <= div_cnt + DIV_W'(1);
    end
  end

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_ev && !start) |=> busy);

  assert_busy_ends_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick_ev));

endmodule

// File: rtl/kfc_array.sv
module kfc_array #(
  parameter logic [15:0] BASE      = 16'h1000,
  parameter int          SEG_BYTES = 128,
  parameter int          NUM_SEG   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        mode_prog,
  input  logic        mode_erase,
  input  logic        locked,
  input  logic        busy,
  output logic [7:0]  bus_rdata,
  output logic        op_start,
  output logic        acc_set
);
  import kfc_pkg::*;

  localparam int DEPTH = SEG_BYTES * NUM_SEG;
  localparam int AW    = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [15:0]   off;
  logic [AW-1:0] idx;
  logic          in_win, allowed;
  logic          prog_ev, erase_ev;
  logic [7:0]    old_byte;
  int            seg_hit;

  assign off      = bus_addr - BASE;
  assign idx      = off[AW-1:0];
  assign in_win   = (bus_addr >= BASE) && ({16'h0, bus_addr} < ({16'h0, BASE} + 32'(DEPTH)));
  assign allowed  = in_win && !locked && !busy && (mode_prog || mode_erase);
  assign erase_ev = bus_we && allowed && mode_erase;
  assign prog_ev  = bus_we && allowed && mode_prog && !mode_erase;
  assign acc_set  = bus_we && !allowed;
  assign op_start = prog_ev || erase_ev;
  assign seg_hit  = 32'(idx) / SEG_BYTES;
  assign old_byte = mem[idx];
  assign bus_rdata = in_win ? old_byte : 8'h00;

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam int SEG = g / SEG_BYTES;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             mem[g] <= 8'hFF;
      else if (erase_ev && seg_hit == SEG)    mem[g] <= 8'hFF;
      else if (prog_ev && 32'(idx) == g)      mem[g] <= prog_merge(mem[g], bus_wdata);
    end
  end

  assert_prog_and_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_ev |=> (mem[$past(idx)] == ($past(old_byte) & $past(bus_wdata))));

  assert_erase_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_ev |=> (mem[$past(idx)] == 8'hFF));

  assert_guarded_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (locked || busy || !(mode_prog || mode_erase))) |-> (acc_set && !op_start));

  assert_outside_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> (bus_rdata == 8'h00 && !op_start));

endmodule

// File: rtl/kfc_top.sv
module kfc_top #(
  parameter logic [7:0]  KEY       = 8'hA5,
  parameter logic [15:0] BASE      = 16'h1000,
  parameter int          SEG_BYTES = 128,
  parameter int          NUM_SEG   = 2,
  parameter int unsigned SRC0_KHZ  = 8000,
  parameter int unsigned SRC1_KHZ  = 1000,
  parameter int          DIV_W     = 6,
  parameter int          LEN_W     = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [15:0] reg_wdata,
  input  logic        bus_we,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic [1:0]  mode_o,
  output logic        locked_o,
  output logic        busy_o,
  output logic        clk_bad_o,
  output logic        key_viol_o,
  output logic        acc_viol_o
);
  logic             mode_prog, mode_erase, locked, busy;
  logic [LEN_W-1:0] len_m1;
  logic [DIV_W-1:0] div_m1;
  logic             op_start, acc_set;

  kfc_regs #(
    .KEY(KEY), .SRC0_KHZ(SRC0_KHZ), .SRC1_KHZ(SRC1_KHZ),
    .FMIN_KHZ(250), .FMAX_KHZ(470), .DIV_W(DIV_W), .LEN_W(LEN_W),
    .CLK_RESET(8'h82)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .acc_set(acc_set),
    .mode_prog(mode_prog), .mode_erase(mode_erase), .locked(locked),
    .len_m1(len_m1), .div_m1(div_m1), .clk_bad(clk_bad_o),
    .key_viol(key_viol_o), .acc_viol(acc_viol_o)
  );

  kfc_timer #(.DIV_W(DIV_W), .LEN_W(LEN_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(op_start),
    .div_m1(div_m1), .len_m1(len_m1), .busy(busy)
  );

  kfc_array #(.BASE(BASE), .SEG_BYTES(SEG_BYTES), .NUM_SEG(NUM_SEG)) array_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .mode_prog(mode_prog), .mode_erase(mode_erase),
    .locked(locked), .busy(busy), .bus_rdata(bus_rdata),
    .op_start(op_start), .acc_set(acc_set)
  );

  assign mode_o   = {mode_erase, mode_prog};
  assign locked_o = locked;
  assign busy_o   = busy;

  assert_start_sets_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> busy);

  assert_erase_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_prog && mode_erase && op_start) |=> (bus_rdata == 8'hFF || $changed(bus_addr)));

endmodule

// File: tb/kfc_top_tb_top.sv
module kfc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic [7:0]  bus_wdata = 8'h0;
  logic [7:0]  bus_rdata;
  logic [1:0]  mode_o;
  logic        locked_o, busy_o, clk_bad_o, key_viol_o, acc_viol_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [7:0] shadow [256];

  always #2 clk = ~clk;

  kfc_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_o(mode_o),
    .locked_o(locked_o), .busy_o(busy_o), .clk_bad_o(clk_bad_o),
    .key_viol_o(key_viol_o), .acc_viol_o(acc_viol_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [7:0] key, input logic [7:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = {key, val};
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic bwrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic check_all(input string req);
    logic [7:0] d;
    int bad = 0;
    int first = -1;
    for (int i = 0; i < 256; i++) begin
      rd(16'h1000 + 16'(i), d);
      if (d !== shadow[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) check(1'b1, req, 0, 0);
    else begin
      rd(16'h1000 + 16'(first), d);
      check(1'b0, req, int'(d), int'(shadow[first]));
    end
  endtask

  function automatic bit exp_bad(input int src, input int dv);
    int rate;
    rate = (src != 0 ? 1000 : 8000) / (dv + 1);
    return (rate < 250) || (rate > 470);
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=0x%0h expected=0x0", cycles);
        finish_run();
      end
    end
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < 256; i++) shadow[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(locked_o === 1'b1 && mode_o === 2'b00 && busy_o === 1'b0, "R1 ctrl",
          int'({locked_o, mode_o, busy_o}), 4'b1000);
    check(key_viol_o === 1'b0 && acc_viol_o === 1'b0 && clk_bad_o === 1'b0, "R1 flags",
          int'({key_viol_o, acc_viol_o, clk_bad_o}), 0);
    check_all("R1 array");

    // R7 divider sweep over both sources
    for (int s = 0; s < 2; s++) begin
      for (int dv = 0; dv < 64; dv++) begin
        wreg(2'd1, 8'hA5, {s[0], 1'b0, dv[5:0]});
        check(clk_bad_o === exp_bad(s, dv), "R7 range", int'(clk_bad_o), int'(exp_bad(s, dv)));
      end
    end
    wreg(2'd1, 8'hA5, 8'h00);   // fastest ticks for the array sweeps

    // R6 locked write
    wreg(2'd0, 8'hA5, 8'h01);
    bwrite(16'h1000, 8'h00);
    check(acc_viol_o === 1'b1, "R6 locked flag", int'(acc_viol_o), 1);
    rd(16'h1000, d);
    check(d === 8'hFF, "R6 locked data", int'(d), 8'hFF);
    // R9 clear flags, keep lock
    wreg(2'd2, 8'hA5, 8'h81);
    check(acc_viol_o === 1'b0 && locked_o === 1'b1, "R9 clear", int'({acc_viol_o, locked_o}), 1);
    // R6 unlocked but idle mode
    wreg(2'd2, 8'hA5, 8'h00);
    wreg(2'd0, 8'hA5, 8'h00);
    bwrite(16'h1010, 8'h00);
    rd(16'h1010, d);
    check(acc_viol_o === 1'b1 && d === 8'hFF, "R6 idle mode", int'({acc_viol_o, d}), 9'h1FF);
    wreg(2'd2, 8'hA5, 8'h80);

    // R2 program sweep, two passes per byte
    wreg(2'd0, 8'hA5, 8'h01);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] p1, p2;
      p1 = 8'((i * 37 + 5) & 255);
      p2 = 8'(i) ^ 8'h5A;
      bwrite(16'h1000 + 16'(i), p1); wait_idle();
      bwrite(16'h1000 + 16'(i), p2); wait_idle();
      shadow[i] = shadow[i] & p1 & p2;
    end
    check_all("R2 program");
    check(acc_viol_o === 1'b0, "R2 no violation", int'(acc_viol_o), 0);

    // R4 outside window
    rd(16'h0FFF, d);
    check(d === 8'h00, "R4 read below", int'(d), 0);
    rd(16'h1100, d);
    check(d === 8'h00, "R4 read above", int'(d), 0);
    bwrite(16'h1100, 8'h00);
    check(acc_viol_o === 1'b1, "R4 write flag", int'(acc_viol_o), 1);
    check_all("R4 array intact");
    wreg(2'd2, 8'hA5, 8'h80);

    // R10 both mode bits: erase wins on segment 1
    wreg(2'd0, 8'hA5, 8'h03);
    bwrite(16'h1085, 8'h00); wait_idle();
    for (int i = 128; i < 256; i++) shadow[i] = 8'hFF;
    check_all("R10 erase priority");
    // R3 erase segment 0 only
    wreg(2'd0, 8'hA5, 8'h02);
    bwrite(16'h107F, 8'h3C); wait_idle();
    for (int i = 0; i < 128; i++) shadow[i] = 8'hFF;
    check_all("R3 erase segment");

    // R8 busy length for several divider/length settings
    for (int k = 0; k < 4; k++) begin
      int dv, ln, n;
      dv = (k * 3) % 7;
      ln = (k * 5 + 1) % 16;
      wreg(2'd1, 8'hA5, {2'b00, 6'(dv)});
      wreg(2'd0, 8'hA5, {4'(ln), 4'h1});
      bwrite(16'h1000 + 16'(k), 8'hF0);
      shadow[k] = shadow[k] & 8'hF0;
      n = 0;
      while (busy_o) begin n++; @(negedge clk); end
      check(n == (ln + 1) * (dv + 1), "R8 busy cycles", n, (ln + 1) * (dv + 1));
    end
    // R8 write during busy is refused
    wreg(2'd1, 8'hA5, 8'h05);
    wreg(2'd0, 8'hA5, 8'h31);
    bwrite(16'h1040, 8'hFE);
    shadow[64] = shadow[64] & 8'hFE;
    bwrite(16'h1041, 8'h00);
    check(busy_o === 1'b1 && acc_viol_o === 1'b1, "R8 reject flag", int'({busy_o, acc_viol_o}), 3);
    wait_idle();
    rd(16'h1041, d);
    check(d === shadow[65], "R8 reject data", int'(d), int'(shadow[65]));
    wreg(2'd2, 8'hA5, 8'h80);

    // R5 wrong key on mode and lock, and unused select
    wreg(2'd0, 8'h5A, 8'h00);
    check(mode_o === 2'b01 && key_viol_o === 1'b1, "R5 bad key mode", int'({mode_o, key_viol_o}), 3'b011);
    wreg(2'd2, 8'hA4, 8'h01);
    check(locked_o === 1'b0, "R5 bad key lock", int'(locked_o), 0);
    wreg(2'd2, 8'hA5, 8'h80);
    wreg(2'd3, 8'hA5, 8'hFF);
    check(mode_o === 2'b01 && locked_o === 1'b0 && key_viol_o === 1'b0, "R5 unused select",
          int'({mode_o, locked_o, key_viol_o}), 4'b0100);
    // R9 relock
    wreg(2'd2, 8'hA5, 8'h01);
    check(locked_o === 1'b1, "R9 relock", int'(locked_o), 1);
    check_all("R6 final array");

    finish_run();
  end
endmodule